// File: doc/BRIEF.md
# Round-Robin Transmit Line Scanner

This block picks which of several serial output lines receives the next transmit character of a terminal multiplexer. Each line that is enabled, whose serialiser is ready, and which is not still holding an undelivered character is a candidate. The block hunts for a candidate starting one position past the line it granted last and wrapping around the end, so every active line gets a turn. The granted line number and a transmit-ready flag are presented for software to read.

Software writes a character to the low byte of the transmit data port. While the master scan enable is on, the character goes out as a one-cycle strobe on the granted line. That line then reports busy until its serialiser signals acceptance, and the hunt runs again on the next cycle. A write to the high byte only records a set of break bits. An interrupt request with a fixed vector follows the ready flag when the interrupt enable is set, and an acknowledge withdraws it.

Top module: `tx_line_scanner`

## Requirements
- R1: After reset, `txReady` is 0, `readyLine` is 0, `irqReq` is 0 and `charStrobe` is all zeros.
- R2: While scanning is enabled and no qualified grant is held, each cycle the block checks lines readyLine+1, readyLine+2, ... modulo NUM_LINES. It grants the first line with `lineEnable`, `lineReady` and no pending character. On the next edge it loads that number into `readyLine` and sets `txReady`.
- R3: If no line qualifies, `txReady` goes to 0 and `readyLine` keeps its previous value.
- R4: A low-byte write (`tdrWrite`=1, `tdrHighByte`=0) with `scanEnable`=1 produces, on the next edge, a one-cycle pulse on `charStrobe[readyLine]` with `charData` equal to `tdrData` and clears `txReady`. With `scanEnable`=0 such a write produces no strobe.
- R5: A high-byte write (`tdrHighByte`=1) loads `tdrData` into `breakBits`. It produces no strobe and leaves `txReady` and `readyLine` unchanged.
- R6: A line that has been sent a character is excluded from the hunt until a pulse on its `lineTaken` bit. The hunt that follows a send runs on the cycle after the write.
- R7: `irqReq` rises on the edge after `txIntEnable` and `txReady` are both 1. It is 1 only if both were 1 in the previous cycle. `irqAck` clears it, and it is not raised again until the condition has dropped and returned. `irqVector` equals BASE_VEC + 4 + 8*MUX_ID.
- R8: With `scanEnable`=0, `txReady` is 0 after the next edge.
- R9: `ctrlClear` sets `readyLine` to 0 and `txReady` to 0 on the next edge. It releases the pending-character mark of every line whose `lineConnected` bit is 0, and connected lines keep theirs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| scanEnable | input | 1 | Master scan enable |
| txIntEnable | input | 1 | Transmit interrupt enable |
| ctrlClear | input | 1 | Controller clear pulse |
| lineEnable | input | NUM_LINES | Per-line transmit enable |
| lineReady | input | NUM_LINES | Per-line serialiser ready |
| lineTaken | input | NUM_LINES | Per-line pulse: serialiser accepted the character |
| lineConnected | input | NUM_LINES | Per-line connected status |
| tdrWrite | input | 1 | Transmit data port write strobe |
| tdrHighByte | input | 1 | Write targets the high (break) byte |
| tdrData | input | DATA_W | Write data |
| charStrobe | output | NUM_LINES | One-cycle character strobe per line |
| charData | output | DATA_W | Character sent with the strobe |
| breakBits | output | DATA_W | Stored break bits |
| readyLine | output | LINE_W | Granted line number |
| txReady | output | 1 | Transmit ready flag |
| irqReq | output | 1 | Transmit interrupt request |
| irqAck | input | 1 | Interrupt acknowledge |
| irqVector | output | VEC_W | Interrupt vector |

## Verification
The bench builds the block with eight lines, a base vector of 192 and multiplexer number 2, so the expected vector is 212 and a nonzero offset is covered. With eight lines, a hunt that starts at line 6 has to wrap past line 7 to reach line 2, which exercises the modulo step. Sparse ready patterns let sends, acceptances, enable masking and a clear with one connected line steer the grant into each corner.

// File: rtl/txscan_pkg.sv
package txscan_pkg;

  typedef struct packed {
    logic clearAll;
    logic sendChar;
    logic storeBreak;
    logic rescan;
    logic dropReady;
  } scanCtrl_t;

endpackage

// File: rtl/txscan_picker.sv
module txscan_picker #(
  parameter int NUM_LINES = 8,
  localparam int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic [NUM_LINES-1:0] cand,
  input  logic [LINE_W-1:0]    after,
  output logic                 found,
  output logic [LINE_W-1:0]    pick
);

  always_comb begin
    found = 1'b0;
    pick  = after;
    for (int k = 1; k <= NUM_LINES; k++) begin
      int idx;
      idx = (int'(after) + k) % NUM_LINES;
      if (!found && cand[idx]) begin
        found = 1'b1;
        pick  = LINE_W'(idx);
      end
    end
  end

endmodule

// File: rtl/txscan_datapath.sv
module txscan_datapath
  import txscan_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int DATA_W = 8,
  localparam int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  scanCtrl_t            ctrl,
  input  logic [NUM_LINES-1:0] lineEnable,
  input  logic [NUM_LINES-1:0] lineReady,
  input  logic [NUM_LINES-1:0] lineTaken,
  input  logic [NUM_LINES-1:0] lineConnected,
  input  logic [DATA_W-1:0]    tdrData,
  output logic                 heldQualifies,
  output logic [NUM_LINES-1:0] charStrobe,
  output logic [DATA_W-1:0]    charData,
  output logic [DATA_W-1:0]    breakBits,
  output logic [LINE_W-1:0]    readyLine,
  output logic                 txReady
);

  logic [NUM_LINES-1:0] busy;
  logic [NUM_LINES-1:0] cand;
  logic [NUM_LINES-1:0] sendMask;
  logic                 pickFound;
  logic [LINE_W-1:0]    pickLine;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    assign cand[g]     = lineEnable[g] & lineReady[g] & ~busy[g];
    assign sendMask[g] = ctrl.sendChar && (readyLine == LINE_W'(g));
  end

  assign heldQualifies = cand[readyLine];

  txscan_picker #(.NUM_LINES(NUM_LINES)) i_picker (
    .cand  (cand),
    .after (readyLine),
    .found (pickFound),
    .pick  (pickLine)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy       <= '0;
      charStrobe <= '0;
      charData   <= '0;
      breakBits  <= '0;
      readyLine  <= '0;
      txReady    <= 1'b0;
    end else begin
      charStrobe <= '0;
      if (ctrl.clearAll) begin
        busy      <= busy & lineConnected;
        readyLine <= '0;
        txReady   <= 1'b0;
      end else begin
        busy <= (busy & ~lineTaken) | sendMask;
        if (ctrl.storeBreak) breakBits <= tdrData;
        if (ctrl.sendChar) begin
          charStrobe <= sendMask;
          charData   <= tdrData;
          txReady    <= 1'b0;
        end else if (ctrl.rescan) begin
          if (pickFound) readyLine <= pickLine;
          txReady <= pickFound;
        end else if (ctrl.dropReady) begin
          txReady <= 1'b0;
        end
      end
    end
  end

  assert_strobe_onehot_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(charStrobe));

  assert_strobe_clears_ready_R4: assert property (@(posedge clk) disable iff (!rstN)
    (|charStrobe) |-> !txReady);

  assert_line_held_on_drop_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(txReady) && !$past(ctrl.clearAll)) |-> $stable(readyLine));

endmodule

// File: rtl/txscan_control.sv
module txscan_control
  import txscan_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      scanEnable,
  input  logic      txIntEnable,
  input  logic      ctrlClear,
  input  logic      tdrWrite,
  input  logic      tdrHighByte,
  input  logic      heldQualifies,
  input  logic      txReady,
  input  logic      irqAck,
  output scanCtrl_t ctrl,
  output logic      irqReq
);

  logic irqCond;
  logic irqCondPrev;

  always_comb begin
    ctrl            = '0;
    ctrl.clearAll   = ctrlClear;
    ctrl.storeBreak = !ctrlClear && tdrWrite && tdrHighByte;
    ctrl.sendChar   = !ctrlClear && tdrWrite && !tdrHighByte && scanEnable;
    ctrl.rescan     = !ctrlClear && scanEnable && !ctrl.sendChar &&
                      !(txReady && heldQualifies);
    ctrl.dropReady  = !scanEnable;
  end

  assign irqCond = txIntEnable && txReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqReq      <= 1'b0;
      irqCondPrev <= 1'b0;
    end else begin
      irqCondPrev <= irqCond;
      if (!irqCond || irqAck) irqReq <= 1'b0;
      else if (!irqCondPrev)  irqReq <= 1'b1;
    end
  end

  assert_irq_follows_cond_R7: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> $past(txIntEnable && txReady));

  assert_ack_clears_irq_R7: assert property (@(posedge clk) disable iff (!rstN)
    irqAck |=> !irqReq);

  assert_scan_off_drops_ready_R8: assert property (@(posedge clk) disable iff (!rstN)
    !scanEnable |=> !txReady);

endmodule

// File: rtl/tx_line_scanner.sv
module tx_line_scanner
  import txscan_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int DATA_W = 8,
  parameter int VEC_W = 9,
  parameter int BASE_VEC = 192,
  parameter int MUX_ID = 2,
  localparam int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  localparam int VEC_VAL = BASE_VEC + 4 + 8 * MUX_ID
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 scanEnable,
  input  logic                 txIntEnable,
  input  logic                 ctrlClear,
  input  logic [NUM_LINES-1:0] lineEnable,
  input  logic [NUM_LINES-1:0] lineReady,
  input  logic [NUM_LINES-1:0] lineTaken,
  input  logic [NUM_LINES-1:0] lineConnected,
  input  logic                 tdrWrite,
  input  logic                 tdrHighByte,
  input  logic [DATA_W-1:0]    tdrData,
  output logic [NUM_LINES-1:0] charStrobe,
  output logic [DATA_W-1:0]    charData,
  output logic [DATA_W-1:0]    breakBits,
  output logic [LINE_W-1:0]    readyLine,
  output logic                 txReady,
  output logic                 irqReq,
  input  logic                 irqAck,
  output logic [VEC_W-1:0]     irqVector
);

  scanCtrl_t ctrl;
  logic      heldQualifies;

  assign irqVector = VEC_W'(VEC_VAL);

  txscan_control i_control (
    .clk           (clk),
    .rstN          (rstN),
    .scanEnable    (scanEnable),
    .txIntEnable   (txIntEnable),
    .ctrlClear     (ctrlClear),
    .tdrWrite      (tdrWrite),
    .tdrHighByte   (tdrHighByte),
    .heldQualifies (heldQualifies),
    .txReady       (txReady),
    .irqAck        (irqAck),
    .ctrl          (ctrl),
    .irqReq        (irqReq)
  );

  txscan_datapath #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W)) i_datapath (
    .clk           (clk),
    .rstN          (rstN),
    .ctrl          (ctrl),
    .lineEnable    (lineEnable),
    .lineReady     (lineReady),
    .lineTaken     (lineTaken),
    .lineConnected (lineConnected),
    .tdrData       (tdrData),
    .heldQualifies (heldQualifies),
    .charStrobe    (charStrobe),
    .charData      (charData),
    .breakBits     (breakBits),
    .readyLine     (readyLine),
    .txReady       (txReady)
  );

endmodule

// File: tb/test_tx_line_scanner.sv
module test_tx_line_scanner;

  localparam int N = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       scanEnable = 1'b0;
  logic       txIntEnable = 1'b0;
  logic       ctrlClear = 1'b0;
  logic [N-1:0] lineEnable = '0;
  logic [N-1:0] lineReady = '0;
  logic [N-1:0] lineTaken = '0;
  logic [N-1:0] lineConnected = '0;
  logic       tdrWrite = 1'b0;
  logic       tdrHighByte = 1'b0;
  logic [7:0] tdrData = '0;
  logic [N-1:0] charStrobe;
  logic [7:0] charData;
  logic [7:0] breakBits;
  logic [2:0] readyLine;
  logic       txReady;
  logic       irqReq;
  logic       irqAck = 1'b0;
  logic [8:0] irqVector;

  int testsRun = 0;
  int testsFailed = 0;
  int cycles = 0;

  tx_line_scanner #(.NUM_LINES(N), .DATA_W(8), .VEC_W(9), .BASE_VEC(192), .MUX_ID(2))
  i_tx_line_scanner (
    .clk(clk), .rstN(rstN), .scanEnable(scanEnable), .txIntEnable(txIntEnable),
    .ctrlClear(ctrlClear), .lineEnable(lineEnable), .lineReady(lineReady),
    .lineTaken(lineTaken), .lineConnected(lineConnected), .tdrWrite(tdrWrite),
    .tdrHighByte(tdrHighByte), .tdrData(tdrData), .charStrobe(charStrobe),
    .charData(charData), .breakBits(breakBits), .readyLine(readyLine),
    .txReady(txReady), .irqReq(irqReq), .irqAck(irqAck), .irqVector(irqVector)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      testsFailed = testsFailed + 1;
      $display("FAIL watchdog: actual %0d cycles, expected under 100000", cycles);
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic check(string req, string what, int act, int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic sendLow(logic [7:0] d);
    tdrWrite = 1'b1; tdrHighByte = 1'b0; tdrData = d;
    tick();
    tdrWrite = 1'b0;
  endtask

  task automatic testReset();
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    check("R1", "txReady", txReady, 0);
    check("R1", "readyLine", readyLine, 0);
    check("R1", "irqReq", irqReq, 0);
    check("R1", "charStrobe", charStrobe, 0);
  endtask

  task automatic testGrantAndSend();
    scanEnable = 1'b1; lineEnable = 8'hFF; lineReady = 8'b0010_0100;
    tick();
    check("R2", "first grant line", readyLine, 2);
    check("R2", "txReady", txReady, 1);
    tick();
    check("R2", "held grant", readyLine, 2);
    sendLow(8'hA5);
    check("R4", "strobe on line 2", charStrobe, 8'h04);
    check("R4", "charData", charData, 8'hA5);
    check("R4", "txReady cleared", txReady, 0);
    tick();
    check("R6", "rescan skips busy line", readyLine, 5);
    check("R6", "txReady after rescan", txReady, 1);
    check("R4", "strobe is one cycle", charStrobe, 0);
    sendLow(8'h3C);
    check("R4", "strobe on line 5", charStrobe, 8'h20);
    tick();
    check("R3", "no candidate txReady", txReady, 0);
    check("R3", "line kept", readyLine, 5);
  endtask

  task automatic testTakenAndWrap();
    lineTaken = 8'h04;
    tick();
    lineTaken = '0;
    tick();
    check("R2", "wrap from 5 to 2", readyLine, 2);
    check("R6", "accepted line qualifies again", txReady, 1);
    lineTaken = 8'h20;
    tick();
    lineTaken = '0;
    check("R2", "held while qualified", readyLine, 2);
    lineEnable = 8'hFB;
    tick();
    check("R2", "disabled line skipped", readyLine, 5);
    lineEnable = 8'hFF;
  endtask

  task automatic testIrq();
    txIntEnable = 1'b1;
    tick();
    check("R7", "irq raised", irqReq, 1);
    check("R7", "vector", irqVector, 212);
    irqAck = 1'b1;
    tick();
    irqAck = 1'b0;
    check("R7", "ack clears", irqReq, 0);
    tick();
    check("R7", "no re-request", irqReq, 0);
    sendLow(8'h11);
    tick();
    check("R6", "rescan grants line 2", readyLine, 2);
    check("R7", "irq not yet", irqReq, 0);
    tick();
    check("R7", "irq on new grant", irqReq, 1);
  endtask

  task automatic testScanOff();
    scanEnable = 1'b0;
    tick();
    check("R8", "txReady dropped", txReady, 0);
    tick();
    check("R7", "irq follows ready", irqReq, 0);
    sendLow(8'h77);
    check("R4", "no strobe when scan off", charStrobe, 0);
    txIntEnable = 1'b0;
  endtask

  task automatic testBreak();
    scanEnable = 1'b1;
    tick();
    check("R2", "regrant line 2", readyLine, 2);
    tdrWrite = 1'b1; tdrHighByte = 1'b1; tdrData = 8'h81;
    tick();
    tdrWrite = 1'b0; tdrHighByte = 1'b0;
    check("R5", "break bits", breakBits, 8'h81);
    check("R5", "no strobe", charStrobe, 0);
    check("R5", "txReady kept", txReady, 1);
    check("R5", "line kept", readyLine, 2);
  endtask

  task automatic testClear();
    sendLow(8'h22);
    tick();
    check("R3", "both busy, none ready", txReady, 0);
    lineConnected = 8'h20;
    ctrlClear = 1'b1;
    tick();
    ctrlClear = 1'b0;
    check("R9", "line field zeroed", readyLine, 0);
    check("R9", "txReady cleared", txReady, 0);
    tick();
    check("R9", "unconnected line released", readyLine, 2);
    check("R9", "ready after clear", txReady, 1);
    lineEnable = 8'hFB;
    tick();
    check("R9", "connected line still busy", txReady, 0);
  endtask

  initial begin
    testReset();
    testGrantAndSend();
    testTakenAndWrap();
    testIrq();
    testScanOff();
    testBreak();
    testClear();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule